// File: doc/BRIEF.md
# Selectable Conversion Tick Generator

This block produces the single-cycle tick that starts each conversion of an analog-to-digital front end. One 16-bit control word, written and read through a simple register port, chooses where the tick comes from. There are four choices: a reference clock divided by a programmable 8-bit value, either of two external clock inputs, or no source at all.

The external inputs are asynchronous to the system clock. Each one passes through a synchronizer and a rising-edge detector, so every rising edge on the selected input gives exactly one tick. The divide value is used only by the internal source. Any write to the control word restarts the internal divider, so after a reconfiguration the first tick comes a full new period later.

Top module: `tick_source_gen`

## Requirements
- R1: After reset, `rd_data` reads 0000h. This selects the internal source with divide field 00h, so `tick` stays low until the register is written.
- R2: A write stores `wr_data[7:0]` as the divide field and `wr_data[9:8]` as the source code. `rd_data` returns both fields at the same positions from the cycle after the write. Bits 15:10 always read zero, whatever is written to them.
- R3: With source code 00 and divide field N in the range 1 to 255, `tick` is high for one cycle in every N+1 system-clock cycles.
- R4: With source code 00 and divide field 00h, `tick` never rises.
- R5: With source code 01, each rising edge on `ext_clk0` gives exactly one tick, and `ext_clk1` has no effect.
- R6: With source code 10, each rising edge on `ext_clk1` gives exactly one tick, and `ext_clk0` has no effect.
- R7: With source code 11, `tick` stays low.
- R8: Every write restarts the internal divider. With source code 00 and divide field N, the first tick falls in the (N+1)-th cycle after the write edge.
- R9: Two ticks are never in consecutive cycles unless a write occurs between them. A level change on an external input that is first sampled at clock edge k raises `tick` between edges k+1 and k+2.
- R10: An external source is never divided. Its tick count equals its rising-edge count whatever the value of the divide field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to store |
| rd_data | output | 16 | Current control word (upper bits zero) |
| ext_clk0 | input | 1 | Asynchronous external clock 0 |
| ext_clk1 | input | 1 | Asynchronous external clock 1 |
| tick | output | 1 | One-cycle conversion tick, system clock domain |

## Verification
The bench builds the block with its default parameters: an 8-bit divide field, a 16-bit control word and a two-stage synchronizer. An 8-bit divide field makes the extreme ratio of 256 cheap to reach, so both ends of the divide range are exercised, along with the reserved zero value. The short synchronizer keeps the edge-to-tick latency at two edges. The reference model can therefore follow it cycle by cycle while both external inputs toggle at the same time.

// File: rtl/tick_pkg.sv
package tick_pkg;

  typedef enum logic [1:0] {
    SRC_INTERNAL = 2'b00,
    SRC_EXT_A    = 2'b01,
    SRC_EXT_B    = 2'b10,
    SRC_NONE     = 2'b11
  } tick_src_e;

  localparam int SRC_W = 2;

endpackage

// File: rtl/tick_cfg_reg.sv
module tick_cfg_reg
  import tick_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output tick_src_e         src_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [DATA_W-1:0] rd_data
);

  localparam int CFG_W   = DIV_W + SRC_W;
  localparam int PAD_W   = DATA_W - CFG_W;
  localparam int SEL_LSB = DIV_W;

  typedef struct packed {
    tick_src_e        src;
    logic [DIV_W-1:0] div;
  } cfg_t;

  cfg_t cfg_q;
  cfg_t cfg_d;
  logic cfg_en;

  always_comb begin
    cfg_en  = wr_en;
    cfg_d   = cfg_q;
    if (wr_en) begin
      cfg_d.div = wr_data[DIV_W-1:0];
      cfg_d.src = tick_src_e'(wr_data[SEL_LSB +: SRC_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{src: SRC_INTERNAL, div: '0};
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign src_o   = cfg_q.src;
  assign div_o   = cfg_q.div;
  assign rd_data = {{PAD_W{1'b0}}, cfg_q};

endmodule

// File: rtl/tick_edge_sync.sv
module tick_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);

  // chain_q[0..STAGES-1] synchronize, chain_q[STAGES] holds the previous level
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-1:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/tick_int_div.sv
module tick_int_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             cnt_en;
  logic             active;
  logic             hit;

  assign active = run && (div_val != '0);
  assign hit    = active && (cnt_q == div_val);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (reload || !active) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else begin
      cnt_en = 1'b1;
      cnt_d  = hit ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign tick_o = hit;

endmodule

// File: rtl/tick_source_gen.sv
module tick_source_gen
  import tick_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ext_clk0,
  input  logic              ext_clk1,
  output logic              tick
);

  localparam int N_EXT = 2;

  tick_src_e        src;
  logic [DIV_W-1:0] div;
  logic             int_tick;
  logic [N_EXT-1:0] ext_in;
  logic [N_EXT-1:0] ext_rise;

  assign ext_in = {ext_clk1, ext_clk0};

  tick_cfg_reg #(
    .DATA_W (DATA_W),
    .DIV_W  (DIV_W)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .src_o   (src),
    .div_o   (div),
    .rd_data (rd_data)
  );

  tick_int_div #(
    .DIV_W (DIV_W)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .reload  (wr_en),
    .run     (src == SRC_INTERNAL),
    .div_val (div),
    .tick_o  (int_tick)
  );

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    tick_edge_sync #(
      .STAGES (SYNC_STAGES)
    ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (ext_in[g]),
      .rise_o   (ext_rise[g])
    );
  end

  always_comb begin
    unique case (src)
      SRC_INTERNAL: tick = int_tick;
      SRC_EXT_A:    tick = ext_rise[0];
      SRC_EXT_B:    tick = ext_rise[1];
      default:      tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/tick_source_chk.sv
module tick_source_chk #(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              tick
);

  localparam int CFG_W = DIV_W + 2;

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:CFG_W] == '0);

  p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[CFG_W-1:0] == $past(wr_data[CFG_W-1:0]));

  p_zero_div_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[CFG_W-1:0] == '0) |-> !tick);

  p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[CFG_W-1:DIV_W] == 2'b11) |-> !tick);

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[CFG_W-1:DIV_W] == 2'b00) |=> !tick);

  p_no_back2back_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en) |=> !tick);

endmodule

bind tick_source_gen tick_source_chk #(
  .DATA_W (DATA_W),
  .DIV_W  (DIV_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .tick    (tick)
);

// File: tb/sim_tick_source_gen.sv
`timescale 1ns/1ps
module sim_tick_source_gen;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        ext_clk0;
  logic        ext_clk1;
  logic        tick;

  int checks;
  int fails;
  int tick_cnt;
  string cur_req;

  tick_source_gen u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .ext_clk0 (ext_clk0),
    .ext_clk1 (ext_clk1),
    .tick     (tick)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural reference
  int       m_cnt;
  int       m_sel;
  int       m_div;
  bit [2:0] m_h0;
  bit [2:0] m_h1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_sel = 0; m_div = 0; m_h0 = '0; m_h1 = '0;
    end else begin
      if (!wr_en && m_sel == 0 && m_div != 0)
        m_cnt = (m_cnt == m_div) ? 0 : m_cnt + 1;
      else
        m_cnt = 0;
      if (wr_en) begin
        m_sel = int'(wr_data[9:8]);
        m_div = int'(wr_data[7:0]);
      end
      m_h0 = {m_h0[1:0], ext_clk0};
      m_h1 = {m_h1[1:0], ext_clk1};
    end
  end

  function automatic bit model_tick();
    case (m_sel)
      0: return (m_div != 0) && (m_cnt == m_div);
      1: return m_h0[1] && !m_h0[2];
      2: return m_h1[1] && !m_h1[2];
      default: return 1'b0;
    endcase
  endfunction

  always @(negedge clk) begin
    bit [15:0] exp_rd;
    exp_rd = {6'b0, 2'(m_sel), 8'(m_div)};
    checks++;
    if (tick !== model_tick()) begin
      fails++;
      $display("FAIL %s tick act=%b exp=%b t=%0t", cur_req, tick, model_tick(), $time);
    end
    checks++;
    if (rd_data !== exp_rd) begin
      fails++;
      $display("FAIL R2 rd_data act=%h exp=%h t=%0t", rd_data, exp_rd, $time);
    end
    if (tick === 1'b1) tick_cnt++;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // write, then count ticks in cycles 1..w after the write edge
  task automatic write_count(input logic [15:0] d, input int w,
                             output int cnt, output int first);
    @(negedge clk); #1; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    cnt = 0; first = 0;
    if (tick) begin cnt = 1; first = 1; end
    #1; wr_en = 1'b0;
    for (int j = 2; j <= w; j++) begin
      @(negedge clk);
      if (tick) begin
        cnt++;
        if (first == 0) first = j;
      end
    end
  endtask

  task automatic pulse_ext(input int which, input int hi, input int lo);
    @(negedge clk); #1;
    if (which == 0) ext_clk0 = 1'b1; else ext_clk1 = 1'b1;
    repeat (hi) @(negedge clk);
    #1;
    if (which == 0) ext_clk0 = 1'b0; else ext_clk1 = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog R1 act=timeout exp=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int c, f;
    checks = 0; fails = 0; tick_cnt = 0; cur_req = "R1";
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; ext_clk0 = 1'b0; ext_clk1 = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset rd_data", int'(rd_data), 0);
    #1; rst_n = 1'b1;
    @(negedge clk); #1; tick_cnt = 0;
    repeat (30) @(negedge clk);
    #1; check("R1 no tick after reset", tick_cnt, 0);

    cur_req = "R2";
    write_count(16'hFC83, 2, c, f);
    check("R2 upper bits dropped", int'(rd_data), 16'h0083);
    write_count(16'hFFFF, 2, c, f);
    check("R2 full readback", int'(rd_data), 16'h03FF);

    cur_req = "R3";
    write_count(16'h0003, 40, c, f);
    check("R3 divide by 4", c, 10);
    write_count(16'h0001, 20, c, f);
    check("R3 divide by 2", c, 10);
    write_count(16'h00FF, 600, c, f);
    check("R3 divide by 256", c, 2);
    check("R8 first tick at 256", f, 256);

    cur_req = "R4";
    write_count(16'h0000, 300, c, f);
    check("R4 zero divide silent", c, 0);

    cur_req = "R8";
    write_count(16'h0004, 3, c, f);
    write_count(16'h0004, 12, c, f);
    check("R8 restart first tick", f, 5);
    write_count(16'h0006, 3, c, f);
    write_count(16'h0009, 25, c, f);
    check("R8 new value first tick", f, 10);

    cur_req = "R5";
    write_count(16'h0105, 2, c, f);
    #1; tick_cnt = 0;
    for (int k = 0; k < 5; k++) begin
      fork
        pulse_ext(0, 4, 3);
        pulse_ext(1, 2, 1);
      join
    end
    repeat (6) @(negedge clk);
    #1; check("R5 R10 ext0 one tick per edge", tick_cnt, 5);

    cur_req = "R9";
    tick_cnt = 0;
    pulse_ext(0, 40, 6);
    #1; check("R9 held level one tick", tick_cnt, 1);

    cur_req = "R6";
    write_count(16'h02FF, 2, c, f);
    #1; tick_cnt = 0;
    for (int k = 0; k < 7; k++) begin
      fork
        pulse_ext(1, 1, 2);
        pulse_ext(0, 1, 1);
      join
    end
    repeat (6) @(negedge clk);
    #1; check("R6 R10 ext1 one tick per edge", tick_cnt, 7);

    cur_req = "R7";
    write_count(16'h0301, 2, c, f);
    #1; tick_cnt = 0;
    for (int k = 0; k < 4; k++) begin
      fork
        pulse_ext(0, 2, 2);
        pulse_ext(1, 3, 1);
      join
    end
    repeat (6) @(negedge clk);
    #1; check("R7 off silent", tick_cnt, 0);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule